// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address into a physical address through a small segment table. The upper bits of the logical address select a segment; the lower bits are a byte offset into that segment. Each segment entry carries a valid flag, a physical base and a size in bytes. A request is legal only if the entry is valid and the offset lies inside the segment. A legal request produces base plus offset, computed by a true adder. An illegal one produces a fault that names the offending segment.

Software fills the table through a one-cycle write port. Requests and responses each use a valid/ready handshake. A response is registered one cycle after its request is accepted. A parameter selects a degenerate variant with a single base/limit pair. In that variant the whole logical address is the offset.

Top module: `seg_xlate`

## Requirements
- R1: In table mode the segment number is `req_addr[LA_W-1:OFS_W]` and the byte offset is `req_addr[OFS_W-1:0]`. A fault response reports that segment number on `rsp_fault_seg`. A legal response reports 0 there.
- R2: A request is legal when its entry is valid and the zero-extended offset is strictly less than the entry size. A legal response has `rsp_pa_ok`=1, `rsp_fault`=0 and `rsp_pa` = (base + offset) mod 2^PA_W, with carries crossing the offset boundary.
- R3: A request to a valid entry whose offset is greater than or equal to the size gives `rsp_fault`=1, `rsp_nomap`=0, `rsp_pa_ok`=0 and `rsp_pa`=0. A size of 0 therefore always faults.
- R4: A request to an entry whose valid flag is 0 gives `rsp_fault`=1, `rsp_nomap`=1, `rsp_pa_ok`=0 and `rsp_pa`=0.
- R5: `req_ready` = !`rsp_valid` || `rsp_ready`. A request accepted at one clock edge has its response on `rsp_valid` from that edge onward. With no accepted request and `rsp_ready`=1, `rsp_valid` drops at the next edge.
- R6: While `rsp_valid`=1 and `rsp_ready`=0, every response output holds its value and no new request is accepted.
- R7: A table write is effective from the edge that follows it. A request accepted in the same cycle as a write to its own entry sees the old contents. Later requests see the new contents.
- R8: After reset `rsp_valid`=0, `req_ready`=1, and every table entry is invalid.
- R9: In base/limit mode (`MODE`=XL_BASELIMIT) the whole logical address is the offset x, checked as x < limit, and a legal result is base + x. Only writes with `tbl_idx`=0 load the pair; writes to other indices are ignored. `rsp_fault_seg` is always 0.
- R10: When `rsp_valid`=1, exactly one of `rsp_pa_ok` and `rsp_fault` is 1. When `rsp_valid`=0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | SEG_W | Entry to write |
| tbl_base | input | PA_W | Physical base to store |
| tbl_size | input | SZ_W (LA_W+1) | Segment size or limit in bytes |
| tbl_valid | input | 1 | Valid flag to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | LA_W (SEG_W+OFS_W) | Logical address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | PA_W | Physical address (0 on fault) |
| rsp_pa_ok | output | 1 | Physical address valid strobe |
| rsp_fault | output | 1 | Protection fault |
| rsp_nomap | output | 1 | Fault caused by an invalid entry |
| rsp_fault_seg | output | SEG_W | Segment number of the faulting request |

## Verification
The table variant is tested with offsets just below, exactly at and far above each segment size. These cases separate a strict from a non-strict comparison and a size check from no check. Bases whose low bits are all ones, and bases near the top of the physical space, expose concatenation used in place of addition, and a lost carry. Requests to invalidated entries are mixed with writes to the same entry in the same cycle, which shows whether the valid flag is used and when a write becomes visible. A stalled consumer, paired with a waiting second request, shows whether results hold and whether the ready path is honoured. The base/limit instance receives the same stimulus, so its whole-address limit and its index-0-only loading are tested against the table variant.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;
   typedef enum logic {
      XL_TABLE     = 1'b0,
      XL_BASELIMIT = 1'b1
   } xl_mode_e;
endpackage

// File: rtl/seg_table.sv
`timescale 1ns/1ps
// Flop-based segment table: one write port, one asynchronous read port.
module seg_table #(
   parameter int IDX_W = 3,
   parameter int PA_W  = 24,
   parameter int SZ_W  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [PA_W-1:0]  wbase,
   input  logic [SZ_W-1:0]  wsize,
   input  logic             wvld,
   input  logic [IDX_W-1:0] ridx,
   output logic [PA_W-1:0]  rbase,
   output logic [SZ_W-1:0]  rsize,
   output logic             rvld
);
   localparam int NENT = 1 << IDX_W;

   logic [PA_W-1:0] base_arr [NENT];
   logic [SZ_W-1:0] size_arr [NENT];
   logic [NENT-1:0] vld_arr;

   for (genvar i = 0; i < NENT; i++) begin : g_ent
      logic [PA_W-1:0] ent_base;
      logic [SZ_W-1:0] ent_size;
      logic            ent_vld;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_base <= '0;
            ent_size <= '0;
            ent_vld  <= 1'b0;
         end else if (we && (widx == IDX_W'(i))) begin
            ent_base <= wbase;
            ent_size <= wsize;
            ent_vld  <= wvld;
         end
      end
      assign base_arr[i] = ent_base;
      assign size_arr[i] = ent_size;
      assign vld_arr[i]  = ent_vld;
   end

   assign rbase = base_arr[ridx];
   assign rsize = size_arr[ridx];
   assign rvld  = vld_arr[ridx];
endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
// Bounds check and base addition for one looked-up entry.
module seg_check #(
   parameter int XW   = 19,
   parameter int PA_W = 24,
   parameter int SZ_W = 20
) (
   input  logic [XW-1:0]   x,
   input  logic [PA_W-1:0] base,
   input  logic [SZ_W-1:0] size,
   input  logic            vld,
   output logic            legal,
   output logic            nomap,
   output logic [PA_W-1:0] pa
);
   localparam int XPAD_SZ = SZ_W - XW;
   localparam int XPAD_PA = PA_W - XW;

   logic [SZ_W-1:0] x_sz;
   logic [PA_W-1:0] x_pa;

   assign x_sz  = {{XPAD_SZ{1'b0}}, x};
   assign x_pa  = {{XPAD_PA{1'b0}}, x};
   assign nomap = !vld;
   assign legal = vld && (x_sz < size);
   assign pa    = base + x_pa;
endmodule

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int       SEG_W = 3,
   parameter int       OFS_W = 16,
   parameter int       PA_W  = 24,
   parameter xl_mode_e MODE  = XL_TABLE,
   localparam int      LA_W  = SEG_W + OFS_W,
   localparam int      SZ_W  = LA_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tbl_we,
   input  logic [SEG_W-1:0] tbl_idx,
   input  logic [PA_W-1:0]  tbl_base,
   input  logic [SZ_W-1:0]  tbl_size,
   input  logic             tbl_valid,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LA_W-1:0]  req_addr,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_pa,
   output logic             rsp_pa_ok,
   output logic             rsp_fault,
   output logic             rsp_nomap,
   output logic [SEG_W-1:0] rsp_fault_seg
);
   localparam int IDX_W = (MODE == XL_TABLE) ? SEG_W : 1;

   if (SEG_W < 1) begin : g_err_seg
      $error("seg_xlate: SEG_W must be at least 1");
   end
   if (OFS_W < 1) begin : g_err_ofs
      $error("seg_xlate: OFS_W must be at least 1");
   end
   if (PA_W < LA_W) begin : g_err_pa
      $error("seg_xlate: PA_W must not be narrower than the logical address");
   end

   logic [SEG_W-1:0] seg_num;
   logic [LA_W-1:0]  x_ofs;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   logic             wr_en;

   if (MODE == XL_TABLE) begin : g_tab
      assign seg_num = req_addr[LA_W-1:OFS_W];
      assign x_ofs   = {{SEG_W{1'b0}}, req_addr[OFS_W-1:0]};
      assign wr_idx  = tbl_idx;
      assign rd_idx  = req_addr[LA_W-1:OFS_W];
      assign wr_en   = tbl_we;
   end else begin : g_bl
      assign seg_num = '0;
      assign x_ofs   = req_addr;
      assign wr_idx  = '0;
      assign rd_idx  = '0;
      assign wr_en   = tbl_we && (tbl_idx == '0);
   end

   logic [PA_W-1:0] ent_base;
   logic [SZ_W-1:0] ent_size;
   logic            ent_vld;
   logic            chk_legal;
   logic            chk_nomap;
   logic [PA_W-1:0] chk_pa;

   seg_table #(
      .IDX_W (IDX_W),
      .PA_W  (PA_W),
      .SZ_W  (SZ_W)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .widx  (wr_idx),
      .wbase (tbl_base),
      .wsize (tbl_size),
      .wvld  (tbl_valid),
      .ridx  (rd_idx),
      .rbase (ent_base),
      .rsize (ent_size),
      .rvld  (ent_vld)
   );

   seg_check #(
      .XW   (LA_W),
      .PA_W (PA_W),
      .SZ_W (SZ_W)
   ) u_check (
      .x     (x_ofs),
      .base  (ent_base),
      .size  (ent_size),
      .vld   (ent_vld),
      .legal (chk_legal),
      .nomap (chk_nomap),
      .pa    (chk_pa)
   );

   assign req_ready = !rsp_valid || rsp_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_pa        <= '0;
         rsp_pa_ok     <= 1'b0;
         rsp_fault     <= 1'b0;
         rsp_nomap     <= 1'b0;
         rsp_fault_seg <= '0;
      end else if (req_ready) begin
         rsp_valid     <= req_valid;
         rsp_pa        <= (req_valid && chk_legal) ? chk_pa : '0;
         rsp_pa_ok     <= req_valid && chk_legal;
         rsp_fault     <= req_valid && !chk_legal;
         rsp_nomap     <= req_valid && chk_nomap;
         rsp_fault_seg <= (req_valid && !chk_legal) ? seg_num : '0;
      end
   end
endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk #(
   parameter int SEG_W = 3,
   parameter int PA_W  = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [PA_W-1:0]  rsp_pa,
   input logic             rsp_pa_ok,
   input logic             rsp_fault,
   input logic             rsp_nomap,
   input logic [SEG_W-1:0] rsp_fault_seg
);
   p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   p_idle_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> req_ready);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) &&
         $stable(rsp_pa_ok) && $stable(rsp_fault) && $stable(rsp_nomap) &&
         $stable(rsp_fault_seg)));

   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_pa_ok != rsp_fault));

   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_pa_ok && !rsp_fault));

   p_nomap_is_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_nomap |-> rsp_fault);

   p_fault_zero_pa_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_pa == '0));
endmodule

bind seg_xlate seg_xlate_chk #(
   .SEG_W (SEG_W),
   .PA_W  (PA_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_pa        (rsp_pa),
   .rsp_pa_ok     (rsp_pa_ok),
   .rsp_fault     (rsp_fault),
   .rsp_nomap     (rsp_nomap),
   .rsp_fault_seg (rsp_fault_seg)
);

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;
   import seg_xlate_pkg::*;

   localparam int SEG_W = 3;
   localparam int OFS_W = 16;
   localparam int PA_W  = 24;
   localparam int LA_W  = SEG_W + OFS_W;
   localparam int SZ_W  = LA_W + 1;
   localparam int NSEG  = 1 << SEG_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tbl_we = 1'b0;
   logic [SEG_W-1:0] tbl_idx = '0;
   logic [PA_W-1:0]  tbl_base = '0;
   logic [SZ_W-1:0]  tbl_size = '0;
   logic             tbl_valid = 1'b0;
   logic             req_valid = 1'b0;
   logic [LA_W-1:0]  req_addr = '0;
   logic             rsp_ready = 1'b1;

   logic             t_req_ready, t_rsp_valid, t_pa_ok, t_fault, t_nomap;
   logic [PA_W-1:0]  t_pa;
   logic [SEG_W-1:0] t_seg;
   logic             s_req_ready, s_rsp_valid, s_pa_ok, s_fault, s_nomap;
   logic [PA_W-1:0]  s_pa;
   logic [SEG_W-1:0] s_seg;

   always #5 clk = ~clk;

   seg_xlate #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W), .MODE(XL_TABLE)) i_seg_xlate (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_base(tbl_base), .tbl_size(tbl_size), .tbl_valid(tbl_valid),
      .req_valid(req_valid), .req_ready(t_req_ready), .req_addr(req_addr),
      .rsp_valid(t_rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(t_pa),
      .rsp_pa_ok(t_pa_ok), .rsp_fault(t_fault), .rsp_nomap(t_nomap),
      .rsp_fault_seg(t_seg));

   seg_xlate #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W), .MODE(XL_BASELIMIT)) i_seg_xlate_bl (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_base(tbl_base), .tbl_size(tbl_size), .tbl_valid(tbl_valid),
      .req_valid(req_valid), .req_ready(s_req_ready), .req_addr(req_addr),
      .rsp_valid(s_rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(s_pa),
      .rsp_pa_ok(s_pa_ok), .rsp_fault(s_fault), .rsp_nomap(s_nomap),
      .rsp_fault_seg(s_seg));

   // reference model
   logic [PA_W-1:0] m_base [NSEG];
   logic [SZ_W-1:0] m_size [NSEG];
   logic            m_vld  [NSEG];
   logic [PA_W-1:0] sb_base;
   logic [SZ_W-1:0] sb_size;
   logic            sb_vld;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_test();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic model_write(input logic [SEG_W-1:0] idx, input logic [PA_W-1:0] b,
                              input logic [SZ_W-1:0] sz, input logic v);
      m_base[idx] = b; m_size[idx] = sz; m_vld[idx] = v;
      if (idx == 0) begin sb_base = b; sb_size = sz; sb_vld = v; end
   endtask

   task automatic wr(input logic [SEG_W-1:0] idx, input logic [PA_W-1:0] b,
                     input logic [SZ_W-1:0] sz, input logic v);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = idx; tbl_base = b; tbl_size = sz; tbl_valid = v;
      @(negedge clk);
      tbl_we = 1'b0;
      model_write(idx, b, sz, v);
   endtask

   // Compare both instances against the model for address a.
   task automatic check_rsp(input logic [LA_W-1:0] a, input string tag);
      logic [SEG_W-1:0] sg;
      logic [SZ_W-1:0]  off;
      logic             ok;
      logic [PA_W-1:0]  pa;
      sg  = a[LA_W-1:OFS_W];
      off = SZ_W'(a[OFS_W-1:0]);
      ok  = m_vld[sg] && (off < m_size[sg]);
      pa  = ok ? (m_base[sg] + PA_W'(off)) : '0;
      chk(tag, "tab valid R5", t_rsp_valid, 1);
      chk(tag, "tab pa R2", t_pa, pa);
      chk(tag, "tab pa_ok R2", t_pa_ok, ok);
      chk(tag, "tab fault R3", t_fault, !ok);
      chk(tag, "tab nomap R4", t_nomap, !m_vld[sg]);
      chk(tag, "tab fault_seg R1", t_seg, ok ? 0 : sg);
      ok = sb_vld && (SZ_W'(a) < sb_size);
      pa = ok ? (sb_base + PA_W'(a)) : '0;
      chk(tag, "bl valid R9", s_rsp_valid, 1);
      chk(tag, "bl pa R9", s_pa, pa);
      chk(tag, "bl pa_ok R9", s_pa_ok, ok);
      chk(tag, "bl fault R9", s_fault, !ok);
      chk(tag, "bl nomap R9", s_nomap, !sb_vld);
      chk(tag, "bl fault_seg R9", s_seg, 0);
   endtask

   task automatic req_cycle(input logic [LA_W-1:0] a, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(a, tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_test();
   end

   initial begin
      for (int i = 0; i < NSEG; i++) begin m_base[i] = '0; m_size[i] = '0; m_vld[i] = 1'b0; end
      sb_base = '0; sb_size = '0; sb_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8", "rsp_valid after reset", t_rsp_valid, 0);
      chk("R8", "req_ready after reset", t_req_ready, 1);
      chk("R8", "bl rsp_valid after reset", s_rsp_valid, 0);
      req_cycle(19'h5_1234, "R8");
      chk("R8", "unmapped after reset", t_nomap, 1);
      @(negedge clk);
      chk("R5", "valid drops when idle", t_rsp_valid, 0);

      // R2 / R3 strict bound
      wr(3'd1, 24'h10_0000, 20'h100, 1'b1);
      req_cycle({3'd1, 16'h00FF}, "R2");
      req_cycle({3'd1, 16'h0100}, "R3");
      chk("R3", "fault at size", t_fault, 1);
      req_cycle({3'd1, 16'hFFFF}, "R3");
      // R2 true addition with carry, and wrap
      wr(3'd2, 24'h00_FFF0, 20'h1_0000, 1'b1);
      req_cycle({3'd2, 16'h0020}, "R2");
      chk("R2", "carry across offset", t_pa, 24'h01_0010);
      req_cycle({3'd2, 16'hFFFF}, "R2");
      wr(3'd3, 24'hFF_FF00, 20'h1_0000, 1'b1);
      req_cycle({3'd3, 16'h0200}, "R2");
      chk("R2", "wrap of pa", t_pa, 24'h00_0100);
      // R3 zero size
      wr(3'd4, 24'h12_3456, 20'h0, 1'b1);
      req_cycle({3'd4, 16'h0000}, "R3");
      // R4 invalidated entry
      wr(3'd1, 24'h10_0000, 20'h100, 1'b0);
      req_cycle({3'd1, 16'h0001}, "R4");
      chk("R4", "nomap on invalid", t_nomap, 1);

      // R7 write and lookup to the same entry in the same cycle
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 3'd2; tbl_base = 24'h30_0000; tbl_size = 20'h40; tbl_valid = 1'b1;
      req_valid = 1'b1; req_addr = {3'd2, 16'h0050};
      @(negedge clk);
      tbl_we = 1'b0; req_valid = 1'b0;
      check_rsp({3'd2, 16'h0050}, "R7");
      chk("R7", "old entry used", t_pa, 24'h01_0040);
      model_write(3'd2, 24'h30_0000, 20'h40, 1'b1);
      req_cycle({3'd2, 16'h0050}, "R7");
      chk("R7", "new size applied", t_fault, 1);
      req_cycle({3'd2, 16'h003F}, "R7");

      // R9 base/limit pair, loaded only through index 0
      wr(3'd0, 24'h20_0000, 20'h5_0000, 1'b1);
      req_cycle(19'h4_FFFF, "R9");
      chk("R9", "bl legal pa", s_pa, 24'h24_FFFF);
      req_cycle(19'h5_0000, "R9");
      chk("R9", "bl at limit", s_fault, 1);
      wr(3'd5, 24'h00_0000, 20'hF_FFFF, 1'b1);
      req_cycle(19'h5_0000, "R9");
      chk("R9", "other index ignored", s_fault, 1);

      // R6 backpressure
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b1; req_addr = {3'd0, 16'h0010};
      @(negedge clk);
      check_rsp({3'd0, 16'h0010}, "R6");
      chk("R6", "req_ready low while stalled", t_req_ready, 0);
      req_addr = {3'd5, 16'h0020};
      @(negedge clk);
      check_rsp({3'd0, 16'h0010}, "R6");
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp({3'd5, 16'h0020}, "R6");
      @(negedge clk);
      chk("R5", "valid drops after drain", t_rsp_valid, 0);
      chk("R10", "no pa_ok when idle", t_pa_ok, 0);

      // constrained random mix
      void'($urandom(32'h5EC7_A11E));
      for (int it = 0; it < 600; it++) begin
         logic [SEG_W-1:0] sg;
         logic [15:0]      off;
         logic [LA_W-1:0]  a;
         if ($urandom_range(3) == 0) begin
            logic [SZ_W-1:0] sz;
            case ($urandom_range(3))
               0: sz = '0;
               1: sz = SZ_W'($urandom_range(300));
               2: sz = 20'h1_0000;
               default: sz = SZ_W'($urandom);
            endcase
            wr(3'($urandom), 24'($urandom), sz, ($urandom_range(4) != 0));
         end
         sg = 3'($urandom);
         case ($urandom_range(3))
            0: off = 16'(m_size[sg] - 1);
            1: off = 16'(m_size[sg]);
            default: off = 16'($urandom);
         endcase
         a = {sg, off};
         if ($urandom_range(3) == 0) a = 19'(sb_size - SZ_W'($urandom_range(1)));
         req_cycle(a, "R2");
      end
      finish_test();
   end
endmodule